// File: doc/BRIEF.md
# Power-Managed Mode Sequencer

This block decides when a small processor runs, idles or sleeps, and drives the enables that gate its CPU clock and its peripheral clock. Software first writes a configuration register that holds an idle-enable bit and a two-bit clock-source field. It then issues a sleep strobe, which is the effect of the sleep instruction. With idle-enable set, the block enters Idle: the CPU clock stops and the peripherals keep running. With idle-enable clear, it enters Sleep, and both clocks stop.

The block leaves Idle or Sleep on an enabled pending interrupt, on a watchdog time-out, or on reset. Every exit passes through a fixed preparation window of `TCSD` cycles. During that window the peripheral clock runs and the CPU clock stays gated. A watchdog time-out has a second meaning: while the CPU is running, it asks for a watchdog reset and does not wake anything. When an interrupt causes the wake and the global interrupt enable is set, the block issues a one-cycle branch-to-vector strobe on the first running cycle.

The clock-source field also drives the primary-oscillator enable. When the upper bit of the field selects the internal oscillator, the primary oscillator is switched off and its ready status is cleared.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, the block is in Run: `mode_o`=0, `cpu_clk_en`=1, `per_clk_en`=1, `idle_en_o`=0, `clk_sel_o`=2'b10 (internal oscillator), `prim_osc_en`=0, `osc_ready`=0, `vector_strobe`=0, `wdt_rst_req`=0. Reset is synchronous and takes effect from any state at the next edge.
- R2: In Run, a sleep strobe with the stored idle-enable at 1 moves the block to Idle (`mode_o`=1) at the next edge. Idle has `cpu_clk_en`=0 and `per_clk_en`=1. A configuration write in the same cycle as the strobe does not affect that decision.
- R3: In Run, a sleep strobe with the stored idle-enable at 0 moves the block to Sleep (`mode_o`=2) at the next edge. Sleep has both clock enables at 0.
- R4: In Idle or Sleep, the block moves to the wake window (`mode_o`=3) at the next edge when a watchdog time-out occurs or when any line has both `irq_flag` and `irq_en` at 1. A flag whose enable is 0 does not wake the block.
- R5: The wake window lasts exactly `TCSD` cycles, with `cpu_clk_en`=0 and `per_clk_en`=1. The block then returns to Run with `cpu_clk_en`=1.
- R6: A watchdog time-out in Run gives a one-cycle `wdt_rst_req` pulse at the next edge. The block stays in Run, and a sleep strobe in that same cycle is dropped. A time-out in Idle, in Sleep or in the wake window never raises `wdt_rst_req`.
- R7: `vector_strobe` pulses for one cycle on the first Run cycle after a wake, but only when an enabled interrupt was present at the wake edge and `gie` was 1 at that edge. A wake by the watchdog alone, or with `gie` at 0, gives no strobe. An interrupt and a time-out arriving together count as an interrupt wake.
- R8: A wake leaves `idle_en_o` and `clk_sel_o` unchanged. Only a write with `cfg_we`=1 changes them, at the next edge.
- R9: During the wake window, sleep strobes, interrupts and watchdog time-outs are ignored. They neither restart nor lengthen the window.
- R10: `prim_osc_en` is 0 whenever `clk_sel_o[1]`=1 and is 1 otherwise. `osc_ready` is 1 exactly when, at the previous edge, `prim_osc_en` and `prim_rdy` were both 1.
- R11: In Idle or Sleep, a sleep strobe has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the mode configuration |
| cfg_idle_en | input | 1 | Idle-enable value to write |
| cfg_clk_sel | input | 2 | Clock-source field to write; bit 1 selects the internal oscillator |
| sleep_strobe | input | 1 | One-cycle strobe from the executed sleep instruction |
| irq_flag | input | N_IRQ | Pending interrupt flags |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| prim_rdy | input | 1 | Primary oscillator stable indication |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| vector_strobe | output | 1 | Branch-to-interrupt-vector strobe |
| wdt_rst_req | output | 1 | Watchdog reset request |
| prim_osc_en | output | 1 | Primary oscillator enable |
| osc_ready | output | 1 | Primary oscillator ready status |
| idle_en_o | output | 1 | Stored idle-enable |
| clk_sel_o | output | 2 | Stored clock-source field |
| mode_o | output | 2 | Mode: 0 Run, 1 Idle, 2 Sleep, 3 wake window |

## Verification
The bench builds the block with `N_IRQ`=4 and `TCSD`=4. With these values every interrupt line can be swept in every combination of idle-enable and clock-source field. The same sweep covers four wake causes: an interrupt with and without `gie`, a time-out, and an interrupt together with a time-out. A four-cycle window is also long enough to inject ignored triggers in its middle and still count the exact cycle of the return to Run. Separate passes cover the oscillator enable and ready status for all four field values, the watchdog reset in Run, a write in the same cycle as a sleep strobe, and reset from Sleep and from the wake window.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2,
        PM_WAKE  = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic       idle_en;
        logic [1:0] clk_sel;
    } pm_cfg_t;

    typedef struct packed {
        logic any;
        logic by_irq;
    } wake_req_t;

    localparam logic [1:0] CLKSEL_RESET = 2'b10;

    function automatic logic uses_intosc(input logic [1:0] sel);
        return sel[1];
    endfunction

    function automatic logic is_stopped(input pm_state_e s);
        return (s == PM_IDLE) || (s == PM_SLEEP);
    endfunction

endpackage

// File: rtl/pmode_cfg_reg.sv
module pmode_cfg_reg
    import pmode_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  pm_cfg_t wr_cfg,
    input  logic    prim_rdy,
    output pm_cfg_t cfg_q,
    output logic    prim_osc_en,
    output logic    osc_ready
);

    logic osc_ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.idle_en <= 1'b0;
            cfg_q.clk_sel <= CLKSEL_RESET;
        end else if (we) begin
            cfg_q <= wr_cfg;
        end
    end

    assign prim_osc_en = !uses_intosc(cfg_q.clk_sel);

    always_ff @(posedge clk) begin
        if (rst) osc_ready_q <= 1'b0;
        else     osc_ready_q <= prim_osc_en && prim_rdy;
    end

    assign osc_ready = osc_ready_q;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));

    // R10
    osc_ready_src_chk: assert property (@(posedge clk) disable iff (rst)
        osc_ready |-> $past(prim_osc_en && prim_rdy));

endmodule

// File: rtl/pmode_wake_detect.sv
module pmode_wake_detect
    import pmode_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    output wake_req_t        wake
);

    logic [N_IRQ-1:0] armed;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign armed[i] = irq_flag[i] & irq_en[i];
    end

    assign wake.by_irq = |armed;
    assign wake.any    = wake.by_irq | wdt_timeout;

    always_comb begin
        // R4
        masked_flag_chk: assert (!(wake.by_irq && ((irq_flag & irq_en) == '0)));
    end

endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
    import pmode_pkg::*;
#(
    parameter int TCSD = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_strobe,
    input  logic      idle_en,
    input  logic      gie,
    input  logic      wdt_timeout,
    input  wake_req_t wake,
    output pm_state_e state,
    output logic      cpu_clk_en,
    output logic      per_clk_en,
    output logic      vector_strobe,
    output logic      wdt_rst_req
);

    localparam int CNT_W = (TCSD > 1) ? $clog2(TCSD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TCSD - 1);

    pm_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_wake_q;
    logic             vec_q;
    logic             wdt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PM_RUN;
            cnt_q      <= '0;
            irq_wake_q <= 1'b0;
            vec_q      <= 1'b0;
            wdt_q      <= 1'b0;
        end else begin
            vec_q <= 1'b0;
            wdt_q <= 1'b0;
            case (state_q)
                PM_RUN: begin
                    if (wdt_timeout) begin
                        wdt_q <= 1'b1;
                    end else if (sleep_strobe) begin
                        state_q <= idle_en ? PM_IDLE : PM_SLEEP;
                    end
                end
                PM_IDLE, PM_SLEEP: begin
                    if (wake.any) begin
                        state_q    <= PM_WAKE;
                        cnt_q      <= '0;
                        irq_wake_q <= wake.by_irq && gie;
                    end
                end
                PM_WAKE: begin
                    if (cnt_q == LAST) begin
                        state_q    <= PM_RUN;
                        vec_q      <= irq_wake_q;
                        irq_wake_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= PM_RUN;
            endcase
        end
    end

    assign state         = state_q;
    assign cpu_clk_en    = (state_q == PM_RUN);
    assign per_clk_en    = (state_q != PM_SLEEP);
    assign vector_strobe = vec_q;
    assign wdt_rst_req   = wdt_q;

    // R2
    sleep_target_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && sleep_strobe && !wdt_timeout)
        |=> (state_q == ($past(idle_en) ? PM_IDLE : PM_SLEEP)));

    // R4
    wake_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (is_stopped(state_q) && wake.any) |=> (state_q == PM_WAKE));

    // R11
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_stopped(state_q) && !wake.any) |=> $stable(state_q));

    // R9
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_WAKE && cnt_q != LAST) |=> (state_q == PM_WAKE));

    // R5
    window_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_WAKE && cnt_q == LAST) |=> (state_q == PM_RUN));

    // R3
    clk_order_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> per_clk_en);

    // R7
    vector_origin_chk: assert property (@(posedge clk) disable iff (rst)
        vector_strobe |-> (state_q == PM_RUN && $past(state_q) == PM_WAKE));

    // R6
    wdt_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |-> $past(state_q == PM_RUN && wdt_timeout));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pmode_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int TCSD  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_idle_en,
    input  logic [1:0]       cfg_clk_sel,
    input  logic             sleep_strobe,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie,
    input  logic             wdt_timeout,
    input  logic             prim_rdy,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             vector_strobe,
    output logic             wdt_rst_req,
    output logic             prim_osc_en,
    output logic             osc_ready,
    output logic             idle_en_o,
    output logic [1:0]       clk_sel_o,
    output logic [1:0]       mode_o
);

    pm_cfg_t   wr_cfg;
    pm_cfg_t   cfg_q;
    wake_req_t wake;
    pm_state_e state;

    assign wr_cfg.idle_en = cfg_idle_en;
    assign wr_cfg.clk_sel = cfg_clk_sel;

    pmode_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .wr_cfg     (wr_cfg),
        .prim_rdy   (prim_rdy),
        .cfg_q      (cfg_q),
        .prim_osc_en(prim_osc_en),
        .osc_ready  (osc_ready)
    );

    pmode_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_flag   (irq_flag),
        .irq_en     (irq_en),
        .wdt_timeout(wdt_timeout),
        .wake       (wake)
    );

    pmode_fsm #(.TCSD(TCSD)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_strobe (sleep_strobe),
        .idle_en      (cfg_q.idle_en),
        .gie          (gie),
        .wdt_timeout  (wdt_timeout),
        .wake         (wake),
        .state        (state),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .vector_strobe(vector_strobe),
        .wdt_rst_req  (wdt_rst_req)
    );

    assign idle_en_o = cfg_q.idle_en;
    assign clk_sel_o = cfg_q.clk_sel;
    assign mode_o    = state;

    // R10
    prim_off_intosc_chk: assert property (@(posedge clk) disable iff (rst)
        clk_sel_o[1] |=> (!osc_ready || !$past(clk_sel_o[1])));

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;

    localparam int N_IRQ = 4;
    localparam int TCSD  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic             cfg_idle_en = 1'b0;
    logic [1:0]       cfg_clk_sel = 2'b00;
    logic             sleep_strobe = 1'b0;
    logic [N_IRQ-1:0] irq_flag = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             gie = 1'b0;
    logic             wdt_timeout = 1'b0;
    logic             prim_rdy = 1'b0;
    logic             cpu_clk_en, per_clk_en, vector_strobe, wdt_rst_req;
    logic             prim_osc_en, osc_ready, idle_en_o;
    logic [1:0]       clk_sel_o, mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_seq #(.N_IRQ(N_IRQ), .TCSD(TCSD)) u_pwr_mode_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idle_en(cfg_idle_en),
        .cfg_clk_sel(cfg_clk_sel), .sleep_strobe(sleep_strobe),
        .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
        .wdt_timeout(wdt_timeout), .prim_rdy(prim_rdy),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .vector_strobe(vector_strobe), .wdt_rst_req(wdt_rst_req),
        .prim_osc_en(prim_osc_en), .osc_ready(osc_ready),
        .idle_en_o(idle_en_o), .clk_sel_o(clk_sel_o), .mode_o(mode_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_reset_state(input string req);
        check({req, " mode"}, mode_o, 0);
        check({req, " cpu_en"}, cpu_clk_en, 1);
        check({req, " per_en"}, per_clk_en, 1);
        check({req, " idle_en"}, idle_en_o, 0);
        check({req, " clk_sel"}, clk_sel_o, 2);
        check({req, " prim_osc_en"}, prim_osc_en, 0);
        check({req, " osc_ready"}, osc_ready, 0);
        check({req, " vector"}, vector_strobe, 0);
        check({req, " wdt_req"}, wdt_rst_req, 0);
    endtask

    task automatic write_cfg(input logic ie, input logic [1:0] sel);
        cfg_we = 1'b1; cfg_idle_en = ie; cfg_clk_sel = sel;
        tick();
        cfg_we = 1'b0;
    endtask

    // one full sleep/wake scenario; kind: 0 irq+gie, 1 irq no gie, 2 wdt, 3 irq+wdt
    task automatic scenario(input logic ie, input logic [1:0] sel,
                            input int kind, input int line);
        int exp_mode;
        int exp_vec;
        write_cfg(ie, sel);
        check("R8 write idle_en", idle_en_o, int'(ie));
        check("R8 write clk_sel", clk_sel_o, int'(sel));
        sleep_strobe = 1'b1;
        tick();
        sleep_strobe = 1'b0;
        exp_mode = ie ? 1 : 2;
        check(ie ? "R2 idle mode" : "R3 sleep mode", mode_o, exp_mode);
        check(ie ? "R2 cpu gated" : "R3 cpu gated", cpu_clk_en, 0);
        check(ie ? "R2 per running" : "R3 per gated", per_clk_en, ie ? 1 : 0);
        // masked flags and a second strobe must not move the mode
        irq_flag = '1; irq_en = '0; sleep_strobe = 1'b1;
        tick();
        irq_flag = '0; sleep_strobe = 1'b0;
        check("R4 masked flag ignored", mode_o, exp_mode);
        check("R11 strobe while stopped", mode_o, exp_mode);
        // wake trigger
        gie = (kind != 1);
        if (kind != 2) begin
            irq_flag[line] = 1'b1; irq_en[line] = 1'b1;
        end
        wdt_timeout = (kind >= 2);
        tick();
        irq_flag = '0; irq_en = '0; wdt_timeout = 1'b0; gie = 1'b0;
        check("R4 wake entry", mode_o, 3);
        check("R5 window cpu gated", cpu_clk_en, 0);
        check("R5 window per running", per_clk_en, 1);
        check("R6 no wdt req when stopped", wdt_rst_req, 0);
        // triggers inside the window
        irq_flag = '1; irq_en = '1; wdt_timeout = 1'b1; sleep_strobe = 1'b1; gie = 1'b1;
        tick();
        irq_flag = '0; irq_en = '0; wdt_timeout = 1'b0; sleep_strobe = 1'b0; gie = 1'b0;
        check("R9 window unaffected", mode_o, 3);
        check("R6 no wdt req in window", wdt_rst_req, 0);
        for (int k = 3; k <= TCSD; k++) begin
            tick();
            check("R5 window length", mode_o, 3);
        end
        tick();
        exp_vec = (kind == 0 || kind == 3) ? 1 : 0;
        check("R5 back to run", mode_o, 0);
        check("R5 cpu running", cpu_clk_en, 1);
        check("R7 vector strobe", vector_strobe, exp_vec);
        check("R8 idle_en kept", idle_en_o, int'(ie));
        check("R8 clk_sel kept", clk_sel_o, int'(sel));
        tick();
        check("R7 vector one cycle", vector_strobe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        check_reset_state("R1 during reset");
        tick();
        rst = 1'b0;
        tick();
        check_reset_state("R1 after reset");

        for (int ie = 0; ie < 2; ie++)
            for (int sel = 0; sel < 4; sel++)
                for (int kind = 0; kind < 4; kind++)
                    for (int line = 0; line < N_IRQ; line++)
                        scenario(ie[0], sel[1:0], kind, line);

        // oscillator control sweep
        for (int sel = 0; sel < 4; sel++)
            for (int rdy = 0; rdy < 2; rdy++) begin
                prim_rdy = rdy[0];
                write_cfg(1'b0, sel[1:0]);
                check("R10 prim_osc_en", prim_osc_en, sel[1] ? 0 : 1);
                tick();
                check("R10 osc_ready", osc_ready, (!sel[1] && rdy[0]) ? 1 : 0);
            end
        prim_rdy = 1'b1;
        write_cfg(1'b0, 2'b00);
        tick();
        check("R10 ready before switch", osc_ready, 1);
        write_cfg(1'b0, 2'b11);
        check("R10 osc off on intosc", prim_osc_en, 0);
        tick();
        check("R10 ready cleared on intosc", osc_ready, 0);
        prim_rdy = 1'b0;

        // watchdog in Run, with a sleep strobe in the same cycle
        wdt_timeout = 1'b1; sleep_strobe = 1'b1;
        tick();
        wdt_timeout = 1'b0; sleep_strobe = 1'b0;
        check("R6 wdt req in run", wdt_rst_req, 1);
        check("R6 stays run", mode_o, 0);
        tick();
        check("R6 wdt req one cycle", wdt_rst_req, 0);

        // write and sleep in the same cycle: old idle_en (0) decides
        cfg_we = 1'b1; cfg_idle_en = 1'b1; cfg_clk_sel = 2'b10; sleep_strobe = 1'b1;
        tick();
        cfg_we = 1'b0; sleep_strobe = 1'b0;
        check("R2 same-cycle write uses old value", mode_o, 2);
        check("R8 same-cycle write lands", idle_en_o, 1);

        // reset from Sleep
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check_reset_state("R11 reset from sleep R1");

        // reset from the wake window
        write_cfg(1'b1, 2'b10);
        sleep_strobe = 1'b1;
        tick();
        sleep_strobe = 1'b0;
        wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
        check("R4 wdt wake", mode_o, 3);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check_reset_state("R1 reset from window");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule